// File: doc/BRIEF.md
# Flash Control-Pin Mode and Protection Front End

This block is the control front end of a byte-wide parallel flash device. It samples the active-low chip, output and write strobes, the address bus, and two high-voltage sense flags: one for the A9 address line and one for the output-enable pin. From these it classifies each bus cycle as a read, a legal write or an inhibited cycle. Low pulses on the chip and write strobes count only once they have lasted a set number of clock samples, so short glitches are rejected.

The block holds one chip-wide protect bit. The bit is set or cleared only by a complete write-strobe pulse that happens under the high-voltage protect or unprotect pin pattern. While the protect bit is set, the write enable to the array is withheld. An identifier mode can be entered in two ways: by the high-voltage pin pattern, or through one-cycle entry and exit pulses from a stub command decoder. In identifier mode, reads return the manufacturer code, the device code or the protection status, depending on address bits 1 and 0. Outside identifier mode, the read data port returns zero, because the array read path belongs to a neighbouring block.

Top module: `flash_ctrl_front`

## Requirements
- R1: `arr_we_o` is high only when the filtered chip and write strobes are both low, the output enable is logically high (`oe_ni`=1 and `hv_oe_i`=0), the protect bit is clear and identifier mode is off.
- R2: A low output enable, a high chip enable or a high write enable each keep `arr_we_o` low.
- R3: A low pulse on `ce_ni` or `we_ni` that is shorter than MIN_LOW consecutive clock samples has no effect. A pulse of MIN_LOW samples or more is accepted.
- R4: When `hv_a9_i`=1, `hv_oe_i`=1, address bit 6 is 0 and chip enable is low, a complete write pulse sets the protect bit.
- R5: Under the same pattern with address bit 6 at 1, a complete write pulse clears the protect bit. After that, the device as a whole reports unprotected.
- R6: The protect bit changes only at the rising edge that ends the write pulse. If the arming pattern is removed before that edge, or the pulse is a glitch, the bit keeps its value.
- R7: Identifier mode is active while `hv_a9_i`=1, `hv_oe_i`=0, chip and output enables are low and write enable is high.
- R8: `id_enter_i` turns on the in-system identifier mode and `id_exit_i` turns it off. When both arrive in the same cycle, the exit wins.
- R9: An identifier-mode read with address bit 1 high returns 8'h01 when the device is protected and 8'h00 when it is not. All other address bits are ignored.
- R10: An identifier-mode read with address bit 1 low returns MFR_CODE when address bit 0 is 0 and DEV_CODE when it is 1.
- R11: After reset, the protect bit is clear, identifier mode is off and no write is enabled.
- R12: `rd_data_o` is 8'h00 whenever `read_o` is low or identifier mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Address bus |
| hv_a9_i | input | 1 | High voltage sensed on A9 |
| hv_oe_i | input | 1 | High voltage sensed on output-enable pin |
| id_enter_i | input | 1 | Command decoder: enter identifier mode |
| id_exit_i | input | 1 | Command decoder: leave identifier mode |
| read_o | output | 1 | Valid read cycle |
| arr_we_o | output | 1 | Write enable to the array |
| id_mode_o | output | 1 | Identifier mode active |
| protected_o | output | 1 | Chip protect bit |
| rd_data_o | output | 8 | Identifier or status byte |

## Verification
Two things can land in the same cycle: the arming pattern being released and the rising write edge that would commit a protect change. The bench provokes this during the exhaustive pin-combination sweep, where every vector returns to idle by dropping the high-voltage flags on the very edge that raises the write strobe. The protect bit is judged unchanged afterwards. The second collision is entry and exit pulses from the command stub arriving together; the bench judges it by the identifier mode that follows.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic ce_low;
    logic we_low;
  } strobe_t;

  function automatic logic [DATA_W-1:0] id_byte(input logic a1, input logic a0,
                                                input logic prot,
                                                input logic [DATA_W-1:0] mfr,
                                                input logic [DATA_W-1:0] dev);
    if (a1) return {{(DATA_W-1){1'b0}}, prot};
    return a0 ? dev : mfr;
  endfunction
endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int MIN_LOW = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic low_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);
  localparam logic [CW-1:0] CTHR = CW'(MIN_LOW - 1);

  logic [CW-1:0] cnt_q;
  logic          low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (raw_ni) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      low_q <= (cnt_q >= CTHR);
    end
  end

  assign low_o = low_q;
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_low_i,
  input  logic we_low_i,
  input  logic hv_both_i,
  input  logic a6_i,
  output logic prot_o
);
  logic we_prev_q, pend_q, prot_q;
  logic armed, we_fall, we_rise;

  assign armed   = hv_both_i & ce_low_i;
  assign we_fall = we_low_i & ~we_prev_q;
  assign we_rise = ~we_low_i & we_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev_q <= 1'b0;
      pend_q    <= 1'b0;
      prot_q    <= 1'b0;
    end else begin
      we_prev_q <= we_low_i;
      if (!armed)       pend_q <= 1'b0;
      else if (we_fall) pend_q <= 1'b1;
      else if (we_rise) pend_q <= 1'b0;
      // commit only at the end of a pulse that began and ended armed
      if (armed && pend_q && we_rise) prot_q <= ~a6_i;
    end
  end

  assign prot_o = prot_q;
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux import flash_fe_pkg::*; #(
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h5A,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h3C
) (
  input  logic              rd_en_i,
  input  logic              id_mode_i,
  input  logic              a1_i,
  input  logic              a0_i,
  input  logic              prot_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (rd_en_i && id_mode_i) data_o = id_byte(a1_i, a0_i, prot_i, MFR_CODE, DEV_CODE);
  end
endmodule

// File: rtl/flash_ctrl_front.sv
module flash_ctrl_front import flash_fe_pkg::*; #(
  parameter int                AW       = 17,
  parameter int                MIN_LOW  = 3,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h5A,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              hv_a9_i,
  input  logic              hv_oe_i,
  input  logic              id_enter_i,
  input  logic              id_exit_i,
  output logic              read_o,
  output logic              arr_we_o,
  output logic              id_mode_o,
  output logic              protected_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NSTB = 2;

  logic [NSTB-1:0] raw_n, low_f;
  strobe_t         stb;
  logic            oe_low, hv_id, id_cmd_q, prot, write_ok;

  assign raw_n = {we_ni, ce_ni};

  for (genvar g = 0; g < NSTB; g++) begin : g_filt
    strobe_filter #(.MIN_LOW(MIN_LOW)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_ni (raw_n[g]),
      .low_o  (low_f[g])
    );
  end

  assign stb.ce_low = low_f[0];
  assign stb.we_low = low_f[1];
  assign oe_low     = ~oe_ni;

  prot_ctrl u_prot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_low_i  (stb.ce_low),
    .we_low_i  (stb.we_low),
    .hv_both_i (hv_a9_i & hv_oe_i),
    .a6_i      (addr_i[6]),
    .prot_o    (prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         id_cmd_q <= 1'b0;
    else if (id_exit_i)  id_cmd_q <= 1'b0;
    else if (id_enter_i) id_cmd_q <= 1'b1;
  end

  assign hv_id     = hv_a9_i & ~hv_oe_i & stb.ce_low & oe_low & ~stb.we_low;
  assign id_mode_o = hv_id | id_cmd_q;
  assign read_o    = stb.ce_low & oe_low & ~stb.we_low & ~hv_oe_i;
  assign write_ok  = stb.ce_low & stb.we_low & ~oe_low & ~hv_oe_i;
  assign arr_we_o  = write_ok & ~prot & ~id_mode_o;
  assign protected_o = prot;

  id_read_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idmux (
    .rd_en_i   (read_o),
    .id_mode_i (id_mode_o),
    .a1_i      (addr_i[1]),
    .a0_i      (addr_i[0]),
    .prot_i    (prot),
    .data_o    (rd_data_o)
  );
endmodule

// File: rtl/flash_ctrl_front_chk.sv
module flash_ctrl_front_chk #(
  parameter int AW      = 17,
  parameter int MIN_LOW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          we_ni,
  input logic [AW-1:0] addr_i,
  input logic          hv_a9_i,
  input logic          hv_oe_i,
  input logic          read_o,
  input logic          arr_we_o,
  input logic          id_mode_o,
  input logic          protected_o,
  input logic [7:0]    rd_data_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  logic [CW-1:0] we_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            we_run_q <= '0;
    else if (we_ni)         we_run_q <= '0;
    else if (we_run_q != CMAX) we_run_q <= we_run_q + 1'b1;
  end

  p_write_cond_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (oe_ni && !hv_oe_i && !protected_o && !id_mode_o && $past(!ce_ni)));

  p_oe_inhibit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> !arr_we_o);

  p_glitch_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (we_run_q >= CMAX));

  p_set_pattern_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protected_o) |-> $past(hv_a9_i && hv_oe_i && !addr_i[6]));

  p_clear_pattern_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protected_o) |-> $past(hv_a9_i && hv_oe_i && addr_i[6]));

  p_no_change_unarmed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hv_a9_i && hv_oe_i) |-> $stable(protected_o));

  p_idle_data_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(read_o && id_mode_o) |-> (rd_data_o == 8'h00));
endmodule

bind flash_ctrl_front flash_ctrl_front_chk #(.AW(AW), .MIN_LOW(MIN_LOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .we_ni       (we_ni),
  .addr_i      (addr_i),
  .hv_a9_i     (hv_a9_i),
  .hv_oe_i     (hv_oe_i),
  .read_o      (read_o),
  .arr_we_o    (arr_we_o),
  .id_mode_o   (id_mode_o),
  .protected_o (protected_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/flash_ctrl_front_tb.sv
`timescale 1ns/1ps
module flash_ctrl_front_tb;
  localparam int AW = 17;
  localparam int MIN_LOW = 3;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'h3C;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic hv_a9_i = 1'b0, hv_oe_i = 1'b0, id_enter_i = 1'b0, id_exit_i = 1'b0;
  logic read_o, arr_we_o, id_mode_o, protected_o;
  logic [7:0] rd_data_o;

  int n_chk = 0, n_err = 0, we_hits = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_ctrl_front #(.AW(AW), .MIN_LOW(MIN_LOW), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .addr_i(addr_i), .hv_a9_i(hv_a9_i), .hv_oe_i(hv_oe_i),
    .id_enter_i(id_enter_i), .id_exit_i(id_exit_i),
    .read_o(read_o), .arr_we_o(arr_we_o), .id_mode_o(id_mode_o),
    .protected_o(protected_o), .rd_data_o(rd_data_o)
  );

  always @(negedge clk) if (arr_we_o) we_hits++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_ni = 1; oe_ni = 1; we_ni = 1; hv_a9_i = 0; hv_oe_i = 0; addr_i = '0;
    wait_n(6);
  endtask

  // full write pulse under the high-voltage pattern; a6 picks unprotect
  task automatic hv_pulse(input logic a6, input int low_len, input bit drop_early);
    hv_a9_i = 1; hv_oe_i = 1; oe_ni = 1; ce_ni = 0; addr_i = '0; addr_i[6] = a6;
    wait_n(6);
    we_ni = 0;
    wait_n(low_len);
    if (drop_early) begin hv_a9_i = 0; hv_oe_i = 0; wait_n(2); end
    we_ni = 1;
    wait_n(6);
    idle();
  endtask

  task automatic id_read(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    ce_ni = 0; oe_ni = 0; we_ni = 1; addr_i = a;
    wait_n(6);
    chk(req, {24'h0, rd_data_o}, {24'h0, exp});
    idle();
  endtask

  task automatic sweep(input logic prot);
    for (int v = 0; v < 32; v++) begin
      logic c, o, w, h9, ho, cl, ol, wl, hid, rd, wok, idm;
      logic [7:0] ed;
      logic [AW-1:0] a;
      {c, o, w, h9, ho} = 5'(v);
      a = AW'(v * 37);
      ce_ni = c; oe_ni = o; we_ni = w; hv_a9_i = h9; hv_oe_i = ho; addr_i = a;
      wait_n(6);
      cl = ~c; ol = ~o; wl = ~w;
      hid = h9 & ~ho & cl & ol & ~wl;
      idm = hid;
      rd  = cl & ol & ~wl & ~ho;
      wok = cl & wl & ~ol & ~ho & ~prot & ~idm;
      ed  = (rd && idm) ? (a[1] ? {7'b0, prot} : (a[0] ? DEV : MFR)) : 8'h00;
      chk("R1/R2 write gate", {31'b0, arr_we_o}, {31'b0, wok});
      chk("R7 hv id mode", {31'b0, id_mode_o}, {31'b0, idm});
      chk("R12 read cycle", {31'b0, read_o}, {31'b0, rd});
      chk("R9/R10/R12 data", {24'b0, rd_data_o}, {24'b0, ed});
      // vectors leave by dropping arming on the same edge as WE rises
      ce_ni = 1; oe_ni = 1; we_ni = 1; hv_a9_i = 0; hv_oe_i = 0;
      wait_n(6);
      chk("R6 protect kept over sweep", {31'b0, protected_o}, {31'b0, prot});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int h0;
    wait_n(3);
    rst_ni = 1;
    wait_n(2);
    // R11 reset state
    chk("R11 protect", {31'b0, protected_o}, 0);
    chk("R11 id mode", {31'b0, id_mode_o}, 0);
    chk("R11 write", {31'b0, arr_we_o}, 0);

    sweep(1'b0);

    // R3 glitch on WE in a legal write
    ce_ni = 0; oe_ni = 1; wait_n(6);
    h0 = we_hits; we_ni = 0; wait_n(MIN_LOW - 1); we_ni = 1; wait_n(6);
    chk("R3 short WE rejected", we_hits - h0, 0);
    h0 = we_hits; we_ni = 0; wait_n(MIN_LOW); we_ni = 1; wait_n(6);
    chk("R3 full WE accepted", 32'(we_hits - h0 > 0), 1);
    idle();
    // R3 glitch on CE with WE held low
    we_ni = 0; oe_ni = 1; wait_n(6);
    h0 = we_hits; ce_ni = 0; wait_n(MIN_LOW - 1); ce_ni = 1; wait_n(6);
    chk("R3 short CE rejected", we_hits - h0, 0);
    idle();

    // R6 glitch under protect pattern
    hv_pulse(1'b0, MIN_LOW - 1, 0);
    chk("R6 glitch no protect", {31'b0, protected_o}, 0);
    // R6 arming removed before WE rise
    hv_pulse(1'b0, 6, 1);
    chk("R6 abort no protect", {31'b0, protected_o}, 0);

    // R6 mid-pulse check then R4 set
    hv_a9_i = 1; hv_oe_i = 1; ce_ni = 0; addr_i = '0; wait_n(6);
    we_ni = 0; wait_n(6);
    chk("R6 no update mid pulse", {31'b0, protected_o}, 0);
    we_ni = 1; wait_n(6);
    chk("R4 protect set", {31'b0, protected_o}, 1);
    idle();

    sweep(1'b1);

    // R8 in-system id mode, R9/R10 reads while protected
    id_enter_i = 1; wait_n(1); id_enter_i = 0; wait_n(1);
    chk("R8 enter", {31'b0, id_mode_o}, 1);
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] a = AW'((k * 4099) ^ (k << 5));
      a[1:0] = 2'(k);
      id_read(a, a[1] ? 8'h01 : (a[0] ? DEV : MFR), a[1] ? "R9 status protected" : "R10 id code");
    end
    // R5 unprotect in id mode keeps id mode, status reads zero
    hv_pulse(1'b1, 6, 0);
    chk("R5 protect cleared", {31'b0, protected_o}, 0);
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a = AW'(k * 9001);
      a[1] = 1'b1;
      id_read(a, 8'h00, "R9 status unprotected");
    end
    // R1 write with protect clear but id mode on: blocked
    h0 = we_hits; ce_ni = 0; oe_ni = 1; we_ni = 0; wait_n(6); we_ni = 1;
    chk("R1 blocked in id mode", we_hits - h0, 0);
    idle();

    // R8 collision: exit wins
    id_enter_i = 1; id_exit_i = 1; wait_n(1); id_enter_i = 0; id_exit_i = 0; wait_n(1);
    chk("R8 exit wins in mode", {31'b0, id_mode_o}, 0);
    id_enter_i = 1; id_exit_i = 1; wait_n(1); id_enter_i = 0; id_exit_i = 0; wait_n(1);
    chk("R8 exit wins idle", {31'b0, id_mode_o}, 0);
    id_read('0, 8'h00, "R12 no id data out of mode");

    // R1 legal write reaches array once unprotected and out of id mode
    h0 = we_hits; ce_ni = 0; oe_ni = 1; we_ni = 0; wait_n(6);
    chk("R1 write enabled", {31'b0, arr_we_o}, 1);
    we_ni = 1; wait_n(2);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule